// File: doc/BRIEF.md
# I2C General Call Receive Controller

This block follows the I2C bus on already filtered SCL and SDA lines and handles the general call: a START followed by an all-zero first address byte, then a second address byte and any data bytes. Whether the block acknowledges the all-zero byte is decided by a software enable. Once it has joined a transfer, the block raises an interrupt on each byte. The interrupt comes either on the falling SCL edge that ends the data bits, so that software can pick ACK or NACK before the acknowledge clock, or on the edge that ends the acknowledge bit, so that software can read the acknowledge the bus carried.

While the interrupt is pending, the block stretches the clock by pulling SCL low. When software arms it as a master before a START, the block transmits the all-zero byte and then a programmed second byte. If another master wins arbitration on the second byte, the block stops driving at once, turns into a receiver and receives the rest of the transfer as a general call slave. SCL generation and bit-rate timing are outside this block; the START and STOP conditions come from the bus.

Top module: `i2c_gcall_rx`

## Requirements
- R1: As a receiver, when a START is followed by a first byte of 0x00 and `gc_ack_en_i` is 1 during that byte's 8th SCL fall, the block pulls SDA low through the acknowledge clock and sets `gc_flag_o`. A master with `gc_ack_en_i` at 1 also sets `gc_flag_o`.
- R2: When `gc_ack_en_i` is 0 for an all-zero first byte received as a slave, SDA is not pulled low, `gc_flag_o` stays 0, no interrupt is raised, and the rest of the transfer is ignored.
- R3: A first byte other than 0x00 is neither acknowledged nor reported. It raises no interrupt and leaves `gc_flag_o` at 0.
- R4: With `int_ninth_i` at 1, `int_o` rises after the SCL fall that ends the acknowledge bit of each byte the block takes part in. `lrb_o` then holds the SDA level sampled on that acknowledge clock (0 means ACK).
- R5: With `int_ninth_i` at 0, `int_o` rises after the 8th SCL fall of a byte and `rx_data_o` already holds that byte, MSB received first. During the following acknowledge clock a slave pulls SDA low exactly when `data_ack_en_i` is 1.
- R6: While `int_o` is 1, `scl_low_o` holds SCL low. A cycle with `int_wr_i`=1 and `int_wdata_i`=1 clears the interrupt. A cycle with `int_wr_i`=1 and `int_wdata_i`=0 leaves it set.
- R7: When `mst_en_i` is 1 at a START, `master_o` becomes 1. The block then puts 0x00 and then `mst_addr2_i` on SDA, MSB first, changing bits only while SCL is low, and it never acknowledges its own bytes.
- R8: If, as master, the block leaves SDA released during the second byte and samples it low on an SCL rise, it sets `al_flag_o`, clears `master_o`, stops driving SDA in the same cycle and sets `gc_flag_o` even when `gc_ack_en_i` is 0. It then receives further bytes as a slave.
- R9: A STOP clears `gc_flag_o`, `master_o` and `int_o` and returns the block to idle. A repeated START also clears `gc_flag_o` and restarts address decoding. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| gc_ack_en_i | input | 1 | Acknowledge the all-zero first byte |
| int_ninth_i | input | 1 | 1: interrupt after acknowledge clock, 0: after the 8th data clock |
| data_ack_en_i | input | 1 | Slave ACK for second address byte and data bytes |
| int_wr_i | input | 1 | Write strobe for the interrupt bit |
| int_wdata_i | input | 1 | Write data; 1 clears the interrupt |
| mst_en_i | input | 1 | Act as master for the transfer that starts next |
| mst_addr2_i | input | 8 | Second address byte sent as master |
| sda_low_o | output | 1 | Pull SDA low |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| gc_flag_o | output | 1 | General call in progress |
| al_flag_o | output | 1 | Arbitration was lost |
| master_o | output | 1 | Block is the transmitting master |
| lrb_o | output | 1 | Last acknowledge bit sampled |
| rx_data_o | output | 8 | Last byte received |
| int_o | output | 1 | Interrupt pending |

## Verification
The hardest case to reach is arbitration loss in the middle of the second address byte. It needs a competing bus agent whose bits match the block's all the way through the first byte, then differ at one bit where the block releases SDA and the competitor pulls it low. The bench acts as that agent. The wired-AND bus model lets the block see the other master's bits, and the bench checks that the byte seen on the bus takes the competitor's value from the losing bit on, that the block then acknowledges as a slave, and that it keeps receiving. The early-interrupt mode is also driven by hand: the bench holds the 8th-fall interrupt, checks that SCL stays stretched and that a zero write does nothing, then picks the acknowledge.

// File: rtl/i2c_gcall_rx.sv
module i2c_gcall_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              gc_ack_en_i,
  input  logic              int_ninth_i,
  input  logic              data_ack_en_i,
  input  logic              int_wr_i,
  input  logic              int_wdata_i,
  input  logic              mst_en_i,
  input  logic [BYTE_W-1:0] mst_addr2_i,
  output logic              sda_low_o,
  output logic              scl_low_o,
  output logic              gc_flag_o,
  output logic              al_flag_o,
  output logic              master_o,
  output logic              lrb_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              int_o
);

  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_W);

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR1, PH_ADDR2, PH_DATA, PH_SKIP} phase_t;

  phase_t            phase;
  logic              scl_q, sda_q, armed;
  logic [CW-1:0]     bitn;
  logic [BYTE_W-1:0] shreg, tx_byte, tx_sh;
  logic              gc_q, al_q, mst_q, lrb_q, int_q;

  logic scl_rise, scl_fall, start_ev, stop_ev, active, ack_slot;
  logic fall8, fall9, mst_tx, tx_bit, mst_low, al_hit, gc_hit;
  logic int_set, slave_ack;

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
  assign active   = phase != PH_IDLE;
  assign ack_slot = armed && bitn == ACK_SLOT;
  assign fall8    = active && scl_fall && armed && bitn == LAST_BIT;
  assign fall9    = active && scl_fall && ack_slot;

  assign tx_byte = (phase == PH_ADDR1) ? '0 : mst_addr2_i;
  assign tx_sh   = tx_byte << bitn;
  assign tx_bit  = tx_sh[BYTE_W-1];
  assign mst_tx  = mst_q && armed && bitn < ACK_SLOT &&
                   (phase == PH_ADDR1 || phase == PH_ADDR2);
  assign mst_low = mst_tx & ~tx_bit;
  assign al_hit  = mst_tx & scl_rise & tx_bit & ~sda_i;

  assign gc_hit  = fall8 && phase == PH_ADDR1 && shreg == '0 && gc_ack_en_i;
  assign int_set = (fall8 && !int_ninth_i && (mst_q || gc_q || gc_hit)) ||
                   (fall9 && int_ninth_i && (mst_q || gc_q) && phase != PH_SKIP);

  assign slave_ack = ack_slot && active && !mst_q && gc_q &&
                     (phase == PH_ADDR1 || data_ack_en_i);

  assign sda_low_o = slave_ack | mst_low;
  assign scl_low_o = int_q;
  assign gc_flag_o = gc_q;
  assign al_flag_o = al_q;
  assign master_o  = mst_q;
  assign lrb_o     = lrb_q;
  assign int_o     = int_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      phase     <= PH_IDLE;
      armed     <= 1'b0;
      bitn      <= '0;
      shreg     <= '0;
      rx_data_o <= '0;
      gc_q      <= 1'b0;
      al_q      <= 1'b0;
      mst_q     <= 1'b0;
      lrb_q     <= 1'b0;
      int_q     <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_ev) begin
        phase <= PH_ADDR1;
        armed <= 1'b0;
        bitn  <= '0;
        gc_q  <= 1'b0;
        al_q  <= 1'b0;
        mst_q <= mst_en_i;
        int_q <= 1'b0;
      end else if (stop_ev) begin
        phase <= PH_IDLE;
        armed <= 1'b0;
        bitn  <= '0;
        gc_q  <= 1'b0;
        mst_q <= 1'b0;
        int_q <= 1'b0;
      end else begin
        if (int_wr_i && int_wdata_i) int_q <= 1'b0;
        if (int_set) int_q <= 1'b1;

        if (active && scl_fall) begin
          if (!armed) begin
            armed <= 1'b1;
          end else if (ack_slot) begin
            bitn <= '0;
            case (phase)
              PH_ADDR1: phase <= (mst_q || gc_q) ? PH_ADDR2 : PH_SKIP;
              PH_ADDR2: phase <= PH_DATA;
              default:  phase <= phase;
            endcase
          end else begin
            bitn <= bitn + 1'b1;
          end
        end

        if (fall8) rx_data_o <= shreg;
        if (gc_hit) gc_q <= 1'b1;

        if (active && scl_rise && armed) begin
          if (bitn < ACK_SLOT) shreg <= {shreg[BYTE_W-2:0], sda_i};
          else lrb_q <= sda_i;
        end

        if (al_hit) begin
          al_q  <= 1'b1;
          mst_q <= 1'b0;
          if (phase == PH_ADDR2) gc_q <= 1'b1;
        end
      end
    end
  end

  // R1
  gc_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low_o && !master_o && phase == PH_ADDR1) |-> gc_flag_o);

  // R4
  int_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_o) |-> $past(scl_fall));

  // R6
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_wr_i && int_wdata_i && !fall8 && !fall9) |=> !int_o);

  // R6
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && int_wr_i && !int_wdata_i && !start_ev && !stop_ev) |=> int_o);

  // R8
  al_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    al_flag_o |-> (!master_o && !mst_low));

  // R9
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!gc_flag_o && !master_o && !int_o));

endmodule

// File: tb/test_i2c_gcall_rx.sv
module test_i2c_gcall_rx;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic gc_ack_en = 1'b0, int_ninth = 1'b1, data_ack_en = 1'b1;
  logic int_wr = 1'b0, int_wdata = 1'b0, mst_en = 1'b0;
  logic [7:0] mst_addr2 = 8'h00;
  logic sda_low, scl_low, gc_flag, al_flag, master, lrb, int_o;
  logic [7:0] rx_data;
  logic scl_w, sda_w;

  assign scl_w = m_scl & ~scl_low;
  assign sda_w = m_sda & ~sda_low;

  i2c_gcall_rx i_i2c_gcall_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .gc_ack_en_i(gc_ack_en), .int_ninth_i(int_ninth), .data_ack_en_i(data_ack_en),
    .int_wr_i(int_wr), .int_wdata_i(int_wdata), .mst_en_i(mst_en),
    .mst_addr2_i(mst_addr2), .sda_low_o(sda_low), .scl_low_o(scl_low),
    .gc_flag_o(gc_flag), .al_flag_o(al_flag), .master_o(master), .lrb_o(lrb),
    .rx_data_o(rx_data), .int_o(int_o)
  );

  int checks = 0, errors = 0;
  logic sw_auto = 1'b1;
  logic [7:0] exp_q[$];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_w) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_n(2);
    m_scl = 1'b1; wait_scl_high(); wait_n(H);
    m_sda = 1'b0; wait_n(H);
    m_scl = 1'b0; wait_n(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_n(H);
    m_scl = 1'b1; wait_scl_high(); wait_n(H);
    m_sda = 1'b1; wait_n(H);
  endtask

  task automatic put_bit(input logic b, output logic s);
    m_sda = b; wait_n(H/2);
    m_scl = 1'b1; wait_scl_high(); wait_n(H/2);
    s = sda_w; wait_n(H/2);
    m_scl = 1'b0; wait_n(H/2);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic [7:0] seen);
    for (int i = 7; i >= 0; i--) begin
      logic s;
      put_bit(b[i], s);
      seen[i] = s;
    end
  endtask

  task automatic byte_ack(input logic [7:0] b, output logic [7:0] seen, output logic ack);
    put_byte(b, seen);
    put_bit(1'b1, ack);
  endtask

  task automatic write_int(input logic v);
    int_wr = 1'b1; int_wdata = v; @(negedge clk);
    int_wr = 1'b0; int_wdata = 1'b0;
  endtask

  // scoreboard monitor: every interrupt must present the next expected byte (R4 R5)
  initial forever begin
    @(posedge int_o);
    @(negedge clk);
    if (exp_q.size() == 0) chk(1'b0, "R2 R3 unexpected interrupt", int'(rx_data), 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(rx_data == e, "R4 R5 byte at interrupt", int'(rx_data), int'(e));
    end
  end

  // software stand-in: clears the interrupt by writing 1
  initial forever begin
    @(negedge clk);
    if (int_o && sw_auto) begin
      wait_n(4);
      if (sw_auto) write_int(1'b1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    logic [7:0] seen;
    logic ack;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R9 reset state
    chk({sda_low, scl_low, gc_flag, al_flag, master, int_o} == 6'b0, "R9 reset outputs",
        int'({sda_low, scl_low, gc_flag, al_flag, master, int_o}), 0);

    // T1: slave general call, interrupt after acknowledge clock
    gc_ack_en = 1'b1; int_ninth = 1'b1; data_ack_en = 1'b1;
    bus_start();
    exp_q.push_back(8'h00);
    byte_ack(8'h00, seen, ack);
    chk(ack == 1'b0, "R1 general call ACK", int'(ack), 0);
    chk(gc_flag == 1'b1, "R1 gc flag set", int'(gc_flag), 1);
    chk(lrb == 1'b0, "R4 lrb after ACK", int'(lrb), 0);
    exp_q.push_back(8'h35);
    byte_ack(8'h35, seen, ack);
    chk(ack == 1'b0, "R5 second byte ACK", int'(ack), 0);
    data_ack_en = 1'b0;
    exp_q.push_back(8'hA6);
    byte_ack(8'hA6, seen, ack);
    chk(ack == 1'b1, "R5 data NACK", int'(ack), 1);
    chk(lrb == 1'b1, "R4 lrb after NACK", int'(lrb), 1);
    wait_n(8);
    bus_stop();
    chk(gc_flag == 1'b0 && int_o == 1'b0, "R9 stop clears", int'({gc_flag, int_o}), 0);

    // T2: general call with acknowledge disabled
    gc_ack_en = 1'b0; data_ack_en = 1'b1;
    bus_start();
    byte_ack(8'h00, seen, ack);
    chk(ack == 1'b1, "R2 no ACK", int'(ack), 1);
    chk(gc_flag == 1'b0, "R2 gc flag clear", int'(gc_flag), 0);
    chk(int_o == 1'b0, "R2 no interrupt", int'(int_o), 0);
    byte_ack(8'h11, seen, ack);
    chk(ack == 1'b1, "R2 rest ignored", int'(ack), 1);
    bus_stop();

    // T3: other address
    gc_ack_en = 1'b1;
    bus_start();
    byte_ack(8'h42, seen, ack);
    chk(ack == 1'b1, "R3 no ACK", int'(ack), 1);
    chk(gc_flag == 1'b0 && int_o == 1'b0, "R3 no flag or interrupt", int'({gc_flag, int_o}), 0);
    bus_stop();

    // T4: early interrupt, manual acknowledge choice
    gc_ack_en = 1'b1; int_ninth = 1'b1; data_ack_en = 1'b1;
    bus_start();
    exp_q.push_back(8'h00);
    byte_ack(8'h00, seen, ack);
    exp_q.push_back(8'h21);
    byte_ack(8'h21, seen, ack);
    wait_n(8);
    sw_auto = 1'b0; int_ninth = 1'b0;
    exp_q.push_back(8'hC3);
    put_byte(8'hC3, seen);
    wait_n(3);
    chk(int_o == 1'b1, "R5 interrupt at 8th fall", int'(int_o), 1);
    chk(rx_data == 8'hC3, "R5 byte ready", int'(rx_data), 'hC3);
    m_sda = 1'b1; m_scl = 1'b1; wait_n(6);
    chk(scl_w == 1'b0, "R6 SCL stretched", int'(scl_w), 0);
    write_int(1'b0); wait_n(2);
    chk(int_o == 1'b1, "R6 write 0 ignored", int'(int_o), 1);
    data_ack_en = 1'b0;
    write_int(1'b1);
    put_bit(1'b1, ack);
    chk(ack == 1'b1, "R5 chosen NACK", int'(ack), 1);
    exp_q.push_back(8'h3C);
    put_byte(8'h3C, seen);
    wait_n(3);
    data_ack_en = 1'b1;
    write_int(1'b1);
    put_bit(1'b1, ack);
    chk(ack == 1'b0, "R5 chosen ACK", int'(ack), 0);
    chk(gc_flag == 1'b1, "R9 gc before restart", int'(gc_flag), 1);
    sw_auto = 1'b1; int_ninth = 1'b1;
    bus_start();
    chk(gc_flag == 1'b0, "R9 repeated start clears gc", int'(gc_flag), 0);
    byte_ack(8'h55, seen, ack);
    chk(ack == 1'b1 && int_o == 1'b0, "R9 new address decoded", int'({ack, int_o}), 2);
    bus_stop();

    // T5: master sends general call without contention
    mst_en = 1'b1; mst_addr2 = 8'h04; gc_ack_en = 1'b1;
    bus_start();
    mst_en = 1'b0;
    chk(master == 1'b1, "R7 master mode", int'(master), 1);
    exp_q.push_back(8'h00);
    byte_ack(8'hFF, seen, ack);
    chk(seen == 8'h00, "R7 first byte on bus", int'(seen), 0);
    chk(ack == 1'b1, "R7 no self ACK", int'(ack), 1);
    chk(gc_flag == 1'b1, "R1 master gc flag", int'(gc_flag), 1);
    exp_q.push_back(8'h04);
    byte_ack(8'hFF, seen, ack);
    chk(seen == 8'h04, "R7 second byte on bus", int'(seen), 4);
    wait_n(8);
    bus_stop();
    chk(master == 1'b0, "R9 stop ends master", int'(master), 0);

    // T6: arbitration lost on second byte
    mst_en = 1'b1; mst_addr2 = 8'h04; gc_ack_en = 1'b0; data_ack_en = 1'b1;
    bus_start();
    mst_en = 1'b0;
    exp_q.push_back(8'h00);
    byte_ack(8'h00, seen, ack);
    chk(gc_flag == 1'b0 && al_flag == 1'b0, "R8 no loss on first byte", int'({gc_flag, al_flag}), 0);
    exp_q.push_back(8'h02);
    put_byte(8'h02, seen);
    chk(seen == 8'h02, "R8 bus follows winner", int'(seen), 2);
    chk(al_flag == 1'b1 && master == 1'b0, "R8 lost and slave", int'({al_flag, master}), 2);
    chk(gc_flag == 1'b1, "R8 gc set on loss", int'(gc_flag), 1);
    put_bit(1'b1, ack);
    chk(ack == 1'b0, "R8 slave ACK after loss", int'(ack), 0);
    exp_q.push_back(8'h5A);
    byte_ack(8'h5A, seen, ack);
    chk(ack == 1'b0, "R8 keeps receiving", int'(ack), 0);
    wait_n(8);
    bus_stop();

    wait_n(10);
    chk(exp_q.size() == 0, "R4 all interrupts seen", exp_q.size(), 0);
    finish_sim();
  end
endmodule